// File: doc/BRIEF.md
# Two-Digit Seconds Counter with Multiplexed Display

This block keeps elapsed seconds from 00 to 59 and then starts again at 00. The units digit runs 0 to 9 and the tens digit runs 0 to 5. Both digits are registers on one system clock. A one-second pulse advances the count. This pulse is a clock enable, not a clock of its own, so the two digits change on the same edge and there is no ripple from one digit to the other.

When the units digit holds 9, the next tick loads 0 instead of counting on. That 9 therefore stays visible for a whole second. The same tick advances the tens digit. The tens digit is a 3-bit toggle-chain up-counter with a terminal detector that turns a would-be 6 into 0, so 60 never appears.

A user reset switch returns everything to 00 on the next edge. The two digits go out as BCD values. They also go out through one shared seven-segment bus with two digit enables, and a free-running refresh counter swaps the enables many times per second.

The block has no streaming data path, so every pin is a plain control or status level. The tick is a single-cycle enable with no back-pressure.

Top module: `sec_stopwatch`

## Requirements
- R1: The reset is synchronous and active-high, and it takes priority over tick. With `rst_sw` high at a rising edge, both digits become 0, the refresh counter becomes 0 and the units display is selected, whatever the value of `tick`.
- R2: With `tick` low at a rising edge, both digits keep their values.
- R3: With `tick` high and the units digit between 0 and 8, the units digit goes up by one on that edge.
- R4: With `tick` high and the units digit at 9, the units digit loads 0 on that edge, so 9 is held for a full tick period.
- R5: The tens digit goes up by one on exactly the edge where the units digit reloads from 9 to 0. On any other edge it holds.
- R6: When the count is 59 and a tick arrives, the count becomes 00. The tens digit never reads 6 or more, and the units digit never reads 10 or more.
- R7: Exactly one of `dig_en` is high at any time. Bit 0 selects the units display and bit 1 selects the tens display. After reset the units display is selected, and the selection swaps after every 2^REFRESH_W clocks.
- R8: `seg` is active-high and carries the pattern of the selected digit. Bit 6 is segment A and bit 0 is segment G. The patterns are 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B (hex).
- R9: `ones_bcd` and `tens_bcd` show the current digit values as 4-bit BCD. The top bit of `tens_bcd` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_sw | input | 1 | Synchronous active-high clear from the user switch |
| tick | input | 1 | One-cycle pulse, once per second |
| ones_bcd | output | 4 | Units digit, BCD |
| tens_bcd | output | 4 | Tens digit, BCD |
| seg | output | 7 | Segments A (bit 6) to G (bit 0), active-high |
| dig_en | output | 2 | Digit enables: bit 0 for units, bit 1 for tens |

## Verification
The digit outputs settle one rising edge after the tick or reset that changes them. The segment bus is a combinational function of registered state, so it is valid in the same cycle as the digits it shows. The digit enables follow the refresh counter and swap on the edge where that counter wraps.

The bench drives its inputs and compares outputs on the falling edge, half a period away from any register update. A behavioural model advances on each rising edge, so every comparison in a cycle sees the result of the edge just before it. Each field's mismatch is tagged with the requirement that governs the edge that produced it.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned BCD_W = 4;
  localparam int unsigned SEG_W = 7;

  // Active-high pattern for one decimal digit; bit 6 = A, bit 0 = G.
  function automatic logic [SEG_W-1:0] seg_pattern(input logic [BCD_W-1:0] d);
    logic [SEG_W-1:0] p;
    case (d)
      4'd0:    p = 7'h7E;
      4'd1:    p = 7'h30;
      4'd2:    p = 7'h6D;
      4'd3:    p = 7'h79;
      4'd4:    p = 7'h33;
      4'd5:    p = 7'h5B;
      4'd6:    p = 7'h5F;
      4'd7:    p = 7'h70;
      4'd8:    p = 7'h7F;
      4'd9:    p = 7'h7B;
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/sw_units_digit.sv
module sw_units_digit #(
  parameter int unsigned LAST = 9,
  parameter int unsigned W    = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         carry
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  logic [W-1:0] q;
  logic         at_last;

  assign at_last = (q == LAST_V);
  assign carry   = step & at_last;
  assign value   = q;

  always_ff @(posedge clk) begin
    if (clr)          q <= '0;
    else if (step)    q <= at_last ? '0 : q + W'(1);
  end

  // R6
  units_range_chk: assert property (@(posedge clk) disable iff (clr)
    q <= LAST_V);

  // R4
  units_reload_chk: assert property (@(posedge clk) disable iff (clr)
    (step && q == LAST_V) |=> (q == '0));

  // R2
  units_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !step |=> $stable(q));
endmodule

// File: rtl/sw_tens_digit.sv
module sw_tens_digit #(
  parameter int unsigned END_CNT = 6,
  parameter int unsigned W       = 3
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] END_V = W'(END_CNT);

  logic [W-1:0] q;
  logic [W-1:0] tog;
  logic [W-1:0] nxt;
  logic         end_hit;

  // Toggle chain: bit i flips when adv is high and every lower bit is 1.
  assign tog[0] = adv;
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign tog[i] = tog[i-1] & q[i-1];
  end

  assign nxt     = q ^ tog;
  assign end_hit = (nxt == END_V);
  assign value   = q;

  always_ff @(posedge clk) begin
    if (clr || end_hit) q <= '0;
    else                q <= nxt;
  end

  // R6
  tens_range_chk: assert property (@(posedge clk) disable iff (clr)
    q < END_V);

  // R5
  tens_step_chk: assert property (@(posedge clk) disable iff (clr)
    (adv && q != END_V - W'(1)) |=> (q == $past(q) + W'(1)));

  // R6
  tens_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    (adv && q == END_V - W'(1)) |=> (q == '0));
endmodule

// File: rtl/sw_disp_scan.sv
module sw_disp_scan
  import sw_pkg::*;
#(
  parameter int unsigned REFRESH_W = 4,
  parameter int unsigned TENS_W    = 3
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [BCD_W-1:0]  units,
  input  logic [TENS_W-1:0] tens,
  output logic [SEG_W-1:0]  seg,
  output logic [1:0]        dig_en
);
  logic [REFRESH_W-1:0] rcnt;
  logic                 sel;
  logic                 wrap;
  logic [BCD_W-1:0]     shown;

  assign wrap = &rcnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      rcnt <= '0;
      sel  <= 1'b0;
    end else begin
      rcnt <= rcnt + REFRESH_W'(1);
      if (wrap) sel <= ~sel;
    end
  end

  assign shown  = sel ? BCD_W'(tens) : units;
  assign seg    = seg_pattern(shown);
  assign dig_en = sel ? 2'b10 : 2'b01;

  // R7
  scan_onehot_chk: assert property (@(posedge clk) disable iff (clr)
    $countones(dig_en) == 1);

  // R7
  scan_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !wrap |=> $stable(dig_en));

  // R7
  scan_swap_chk: assert property (@(posedge clk) disable iff (clr)
    wrap |=> (dig_en != $past(dig_en)));
endmodule

// File: rtl/sec_stopwatch.sv
module sec_stopwatch
  import sw_pkg::*;
#(
  parameter int unsigned REFRESH_W = 4,
  parameter int unsigned UNITS_MAX = 9,
  parameter int unsigned TENS_END  = 6
) (
  input  logic              clk,
  input  logic              rst_sw,
  input  logic              tick,
  output logic [BCD_W-1:0]  ones_bcd,
  output logic [BCD_W-1:0]  tens_bcd,
  output logic [SEG_W-1:0]  seg,
  output logic [1:0]        dig_en
);
  localparam int unsigned TENS_W = $clog2(TENS_END + 1);

  logic [BCD_W-1:0]  units_q;
  logic [TENS_W-1:0] tens_q;
  logic              carry;

  sw_units_digit #(.LAST(UNITS_MAX), .W(BCD_W)) u_units (
    .clk   (clk),
    .clr   (rst_sw),
    .step  (tick),
    .value (units_q),
    .carry (carry)
  );

  sw_tens_digit #(.END_CNT(TENS_END), .W(TENS_W)) u_tens (
    .clk   (clk),
    .clr   (rst_sw),
    .adv   (carry),
    .value (tens_q)
  );

  sw_disp_scan #(.REFRESH_W(REFRESH_W), .TENS_W(TENS_W)) u_scan (
    .clk    (clk),
    .clr    (rst_sw),
    .units  (units_q),
    .tens   (tens_q),
    .seg    (seg),
    .dig_en (dig_en)
  );

  assign ones_bcd = units_q;
  assign tens_bcd = BCD_W'(tens_q);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst_sw |=> (ones_bcd == '0 && tens_bcd == '0 && dig_en == 2'b01));

  // R9
  tens_msb_chk: assert property (@(posedge clk) disable iff (rst_sw)
    tens_bcd[BCD_W-1] == 1'b0);
endmodule

// File: tb/sec_stopwatch_bench.sv
module sec_stopwatch_bench;
  localparam int REFRESH_W = 4;
  localparam int SCAN_LEN  = 1 << REFRESH_W;

  logic       clk = 1'b0;
  logic       rst_sw = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] ones_bcd, tens_bcd;
  logic [6:0] seg;
  logic [1:0] dig_en;

  int total = 0;
  int bad   = 0;
  bit armed = 1'b0;
  bit done  = 1'b0;

  // behavioural reference state
  int m_ones, m_tens, m_scan, m_sel;
  string tag_o, tag_t;

  always #2.5 clk = ~clk;

  sec_stopwatch #(.REFRESH_W(REFRESH_W)) u_sec_stopwatch (
    .clk(clk), .rst_sw(rst_sw), .tick(tick),
    .ones_bcd(ones_bcd), .tens_bcd(tens_bcd), .seg(seg), .dig_en(dig_en)
  );

  function automatic logic [6:0] expect_seg(input int d);
    case (d)
      0: return 7'h7E; 1: return 7'h30; 2: return 7'h6D; 3: return 7'h79;
      4: return 7'h33; 5: return 7'h5B; 6: return 7'h5F; 7: return 7'h70;
      8: return 7'h7F; 9: return 7'h7B; default: return 7'h00;
    endcase
  endfunction

  // Reference model: advances on each rising edge from the inputs held since the falling edge.
  always @(posedge clk) begin
    if (rst_sw) begin
      m_ones = 0; m_tens = 0; m_scan = 0; m_sel = 0;
      tag_o = "R1"; tag_t = "R1";
      armed = 1'b1;
    end else begin
      if (!tick) begin
        tag_o = "R2"; tag_t = "R2";
      end else if (m_ones == 9) begin
        tag_o = "R4";
        tag_t = (m_tens == 5) ? "R6" : "R5";
        m_ones = 0;
        m_tens = (m_tens + 1) % 6;
      end else begin
        tag_o = "R3"; tag_t = "R5";
        m_ones = m_ones + 1;
      end
      m_scan = m_scan + 1;
      if (m_scan == SCAN_LEN) begin
        m_scan = 0;
        m_sel  = 1 - m_sel;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Comparisons on the falling edge, away from register updates.
  always @(negedge clk) begin
    if (armed && !done) begin
      chk(tag_o, "ones_bcd", int'(ones_bcd), m_ones);
      chk(tag_t, "tens_bcd", int'(tens_bcd), m_tens);
      chk("R9", "tens_bcd msb", int'(tens_bcd[3]), 0);
      chk("R7", "dig_en", int'(dig_en), (m_sel != 0) ? 2 : 1);
      chk("R8", "seg", int'(seg), int'(expect_seg((m_sel != 0) ? m_tens : m_ones)));
    end
  end

  task automatic run(input int cycles, input int every);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      tick = (every > 0) && ((i % every) == 0);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_sw = 1'b0;
        run(135, 1);          // full 00..59 sweep twice, wraps at 59 (R6)
        run(60, 3);           // sparse ticks, holds between them (R2)
        run(40, 0);           // no ticks at all (R2)
        run(25, 1);
        @(negedge clk);
        rst_sw = 1'b1; tick = 1'b1;  // reset mid-count with tick high (R1)
        @(negedge clk);
        rst_sw = 1'b0; tick = 1'b0;
        run(75, 1);
        run(10, 0);
        @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule